// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is a memory-mapped general-purpose I/O controller for up to 64 pins. The pins are split into banks of 32, and each bank takes one 32-bit word in every register array. Software chooses a direction for each pin. It changes output latches only through atomic write-one-to-set and write-one-to-clear registers, and it reads live pin levels through a two-flop synchronizer.

Each input can latch a pending event when it sees a rising edge, a falling edge or either edge. It can also latch an event on a high or a low level. Pending bits are cleared by writing ones. They are gated by a per-pin enable mask and then ORed into a single interrupt output. A per-pin bypass bit chooses between the raw synchronized input and a glitch filter that needs two matching samples. The register bus is a simple one-cycle strobe interface with registered read data.

Top module: `gpio_bank`

## Requirements
- R1: While reset is held, and until the first register write after it, padOut, padOe and irqOut are all zero and every readable register reads zero. In particular, the rising-edge and falling-edge enable words read zero.
- R2: Register offsets are fixed as follows: level 0x004, direction 0x01C, set 0x034, clear 0x04C, rise enable 0x064, fall enable 0x07C, filter bypass 0x094, mask 0x0AC, status 0x0C4, type 0x300, polarity 0x318. Pin n is bit n mod 32 of the word at offset + 4·(n div 32).
- R3: A direction bit of 1 drives the matching padOe bit high, and the direction word reads back as written. A 0 makes the pin an input.
- R4: A 1 written to a set bit drives the matching padOut bit high, and a 1 written to a clear bit drives it low. A 0 bit leaves the latch as it is. Reads of the set and clear offsets return zero.
- R5: A read returns data on regRdata in the cycle after the read strobe. The level word returns padIn after the synchronizer.
- R6: When a pin's type bit is 0 (edge mode), its status bit is set by a rising edge if rise enable is 1, by a falling edge if fall enable is 1, and by either edge if both are 1.
- R7: When a pin's type bit is 1 (level mode), its status bit is set while the input sits at the active level. The active level is high when the polarity bit is 0 and low when it is 1. A clear written while the level is still active does not take effect.
- R8: Writing a 1 to a status bit clears that bit. A 0 leaves it unchanged.
- R9: irqOut is 1 exactly when some pin has both its status bit and its mask bit at 1.
- R10: When a pin's bypass bit is 0, a change must be seen in two consecutive synchronized samples before it reaches detection, so a one-cycle pulse is dropped and a two-cycle pulse is kept. When the bypass bit is 1, a one-cycle pulse is detected.
- R11: In edge mode, a pin whose rise and fall enables are both 0 never sets its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regEn | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 for write, 0 for read |
| regAddr | input | 12 | Byte address of the register word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the cycle after the strobe |
| padIn | input | NUM_PINS | Pin input levels |
| padOut | output | NUM_PINS | Output latch values |
| padOe | output | NUM_PINS | Output enables (1 = drive) |
| irqOut | output | 1 | Combined masked interrupt |

## Verification
A corrupted output latch or direction bit appears on padOut or padOe one cycle after the write that caused it. A wrong pending bit appears on irqOut in the same cycle for any unmasked pin, and on a status read two cycles after the access. Faults in the detection path (wrong edge polarity, a filter that passes one-cycle pulses, a level clear that wins over an active level) show up as a status word that differs from a model fed the same pin waveform. That difference is visible within about eight cycles of the pin change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 12;
  localparam int BANK_IDX_W = 4;
  localparam int NUM_KINDS = 12;

  typedef enum logic [3:0] {
    KIND_NONE,
    KIND_LEVEL,
    KIND_DIR,
    KIND_SET,
    KIND_CLR,
    KIND_RISE,
    KIND_FALL,
    KIND_BYPASS,
    KIND_MASK,
    KIND_STATUS,
    KIND_TYPE,
    KIND_POLARITY
  } regKind_e;

  typedef struct packed {
    logic rdStb;
    logic wrStb;
    regKind_e kind;
    logic [BANK_IDX_W-1:0] bank;
  } busStrobe_t;

  function automatic logic [ADDR_W-1:0] kindBase(regKind_e k);
    case (k)
      KIND_LEVEL:    return 12'h004;
      KIND_DIR:      return 12'h01C;
      KIND_SET:      return 12'h034;
      KIND_CLR:      return 12'h04C;
      KIND_RISE:     return 12'h064;
      KIND_FALL:     return 12'h07C;
      KIND_BYPASS:   return 12'h094;
      KIND_MASK:     return 12'h0AC;
      KIND_STATUS:   return 12'h0C4;
      KIND_TYPE:     return 12'h300;
      KIND_POLARITY: return 12'h318;
      default:       return 12'hFFF;
    endcase
  endfunction
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic              regEn,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output busStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_BANKS * 4);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off;
  regKind_e          kd;

  // Each kind owns NUM_BANKS consecutive words starting at its base.
  always_comb begin
    strobe      = '0;
    strobe.kind = KIND_NONE;
    base        = '0;
    off         = '0;
    kd          = KIND_NONE;
    for (int k = 1; k < NUM_KINDS; k++) begin
      kd   = regKind_e'(k);
      base = kindBase(kd);
      off  = regAddr - base;
      if (regEn && (regAddr >= base) && (off < SPAN) && (off[1:0] == 2'b00)) begin
        strobe.kind  = kd;
        strobe.bank  = BANK_IDX_W'(off[ADDR_W-1:2]);
        strobe.wrStb = regWrite;
        strobe.rdStb = !regWrite;
      end
    end
  end
endmodule

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
  parameter int WIDTH      = 32,
  parameter bit HAS_FILTER = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  input  logic [WIDTH-1:0] bypass,
  output logic [WIDTH-1:0] syncLevel,
  output logic [WIDTH-1:0] detIn
);
  logic [WIDTH-1:0] metaQ, syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaQ <= '0;
      syncQ <= '0;
    end else begin
      metaQ <= rawIn;
      syncQ <= metaQ;
    end
  end

  assign syncLevel = syncQ;

  if (HAS_FILTER) begin : gFilter
    logic [WIDTH-1:0] sampQ, filtQ, agree;
    assign agree = ~(syncQ ^ sampQ);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sampQ <= '0;
        filtQ <= '0;
      end else begin
        sampQ <= syncQ;
        filtQ <= (agree & syncQ) | (~agree & filtQ);
      end
    end
    assign detIn = (bypass & syncQ) | (~bypass & filtQ);
  end else begin : gNoFilter
    assign detIn = syncQ;
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int NUM_PINS   = 64,
  parameter bit HAS_FILTER = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  busStrobe_t                  strobe,
  input  logic [WORD_W-1:0]           wdata,
  input  logic [NUM_BANKS*WORD_W-1:0] rawIn,
  output logic [WORD_W-1:0]           rdata,
  output logic [NUM_BANKS*WORD_W-1:0] outLatch,
  output logic [NUM_BANKS*WORD_W-1:0] dirOut,
  output logic                        irq
);
  localparam int PADW  = NUM_BANKS * WORD_W;
  localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [PADW-1:0] VALID = PADW'({NUM_PINS{1'b1}});

  typedef logic [NUM_BANKS-1:0][WORD_W-1:0] bankArr_t;

  bankArr_t outQ, dirQ, riseQ, fallQ, bypQ, maskQ, statQ, typeQ, polQ;
  bankArr_t syncLvl, detIn, prevDetQ, setEvt;
  logic [NUM_BANKS-1:0] wrSel;
  logic [SEL_W-1:0]     rdBank;
  logic [WORD_W-1:0]    readWord;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    gpio_in_cond #(
      .WIDTH(WORD_W),
      .HAS_FILTER(HAS_FILTER)
    ) uCond (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (rawIn[b*WORD_W +: WORD_W]),
      .bypass   (bypQ[b]),
      .syncLevel(syncLvl[b]),
      .detIn    (detIn[b])
    );

    // Level mode: active level is detIn XOR polarity. Edge mode: enabled transitions.
    assign setEvt[b] = VALID[b*WORD_W +: WORD_W] &
                       ((typeQ[b] & (detIn[b] ^ polQ[b])) |
                        (~typeQ[b] & ((detIn[b] & ~prevDetQ[b] & riseQ[b]) |
                                      (~detIn[b] & prevDetQ[b] & fallQ[b]))));

    assign wrSel[b] = strobe.wrStb && (strobe.bank == BANK_IDX_W'(b));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ     <= '0;
      dirQ     <= '0;
      riseQ    <= '0;
      fallQ    <= '0;
      bypQ     <= '0;
      maskQ    <= '0;
      statQ    <= '0;
      typeQ    <= '0;
      polQ     <= '0;
      prevDetQ <= '0;
    end else begin
      prevDetQ <= detIn;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (wrSel[b]) begin
          case (strobe.kind)
            KIND_DIR:      dirQ[b]  <= wdata;
            KIND_SET:      outQ[b]  <= outQ[b] | wdata;
            KIND_CLR:      outQ[b]  <= outQ[b] & ~wdata;
            KIND_RISE:     riseQ[b] <= wdata;
            KIND_FALL:     fallQ[b] <= wdata;
            KIND_BYPASS:   bypQ[b]  <= wdata;
            KIND_MASK:     maskQ[b] <= wdata;
            KIND_TYPE:     typeQ[b] <= wdata;
            KIND_POLARITY: polQ[b]  <= wdata;
            default: ;
          endcase
        end
        // A new event wins over a clear in the same cycle.
        statQ[b] <= (statQ[b] & ~((wrSel[b] && strobe.kind == KIND_STATUS) ? wdata : '0))
                    | setEvt[b];
      end
    end
  end

  assign rdBank = SEL_W'(strobe.bank);

  always_comb begin
    case (strobe.kind)
      KIND_LEVEL:    readWord = syncLvl[rdBank];
      KIND_DIR:      readWord = dirQ[rdBank];
      KIND_RISE:     readWord = riseQ[rdBank];
      KIND_FALL:     readWord = fallQ[rdBank];
      KIND_BYPASS:   readWord = bypQ[rdBank];
      KIND_MASK:     readWord = maskQ[rdBank];
      KIND_STATUS:   readWord = statQ[rdBank];
      KIND_TYPE:     readWord = typeQ[rdBank];
      KIND_POLARITY: readWord = polQ[rdBank];
      default:       readWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else if (strobe.rdStb) rdata <= readWord;
  end

  assign outLatch = outQ;
  assign dirOut   = dirQ;
  assign irq      = |(statQ & maskQ);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PINS   = 64,
  parameter bit HAS_FILTER = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regEn,
  input  logic                regWrite,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [WORD_W-1:0]   regWdata,
  output logic [WORD_W-1:0]   regRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqOut
);
  localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int PADW      = NUM_BANKS * WORD_W;

  busStrobe_t      strobe;
  logic [PADW-1:0] rawIn, outLatch, dirOut;

  assign rawIn = PADW'(padIn);

  gpio_ctrl #(.NUM_BANKS(NUM_BANKS)) uCtrl (
    .regEn   (regEn),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  gpio_datapath #(
    .NUM_BANKS (NUM_BANKS),
    .NUM_PINS  (NUM_PINS),
    .HAS_FILTER(HAS_FILTER)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wdata   (regWdata),
    .rawIn   (rawIn),
    .rdata   (regRdata),
    .outLatch(outLatch),
    .dirOut  (dirOut),
    .irq     (irqOut)
  );

  assign padOut = outLatch[NUM_PINS-1:0];
  assign padOe  = dirOut[NUM_PINS-1:0];
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                regEn,
  input logic                regWrite,
  input logic [11:0]         regAddr,
  input logic [31:0]         regWdata,
  input logic [31:0]         regRdata,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic                irqOut
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (padOut == '0 && padOe == '0 && !irqOut));

  // R4
  set_drives_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regEn && regWrite && regAddr == 12'h034)
    |=> ((padOut[31:0] & $past(regWdata)) == $past(regWdata)));

  // R4
  clear_drives_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regEn && regWrite && regAddr == 12'h04C)
    |=> ((padOut[31:0] & $past(regWdata)) == '0));

  // R3
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regEn && regWrite && regAddr == 12'h01C)
    |=> (padOe[31:0] == $past(regWdata)));

  // R4
  writeonly_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regEn && !regWrite && (regAddr == 12'h034 || regAddr == 12'h04C))
    |=> (regRdata == '0));
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .regEn   (regEn),
  .regWrite(regWrite),
  .regAddr (regAddr),
  .regWdata(regWdata),
  .regRdata(regRdata),
  .padOut  (padOut),
  .padOe   (padOe),
  .irqOut  (irqOut)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int NP = 64;
  localparam logic [11:0] A_LEVEL = 12'h004, A_DIR = 12'h01C, A_SET = 12'h034,
                          A_CLR = 12'h04C, A_RISE = 12'h064, A_FALL = 12'h07C,
                          A_BYP = 12'h094, A_MASK = 12'h0AC, A_STAT = 12'h0C4,
                          A_TYPE = 12'h300, A_POL = 12'h318;

  logic clk = 1'b0, rstN = 1'b1, regEn = 1'b0, regWrite = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic [NP-1:0] padIn = '0, padOut, padOe;
  logic irqOut;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [63:0] mOut = '0, mDir = '0, mRise = '0, mFall = '0, mMask = '0;
  logic [63:0] mStat = '0, mType = '0, mPol = '0, mPad = '0;

  gpio_bank dut (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regEn = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regEn = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regEn = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    d = regRdata;
    regEn = 1'b0;
  endtask

  task automatic rd64(logic [11:0] base, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(base, lo);
    rd(base + 12'd4, hi);
    v = {hi, lo};
  endtask

  // Register write with model update (pin n at bit n%32 of base + 4*(n/32)).
  task automatic wrReg(logic [11:0] base, int bank, logic [31:0] d);
    int sh;
    sh = bank * 32;
    wr(base + 12'(bank * 4), d);
    case (base)
      A_DIR:  mDir[sh +: 32] = d;
      A_SET:  mOut[sh +: 32] = mOut[sh +: 32] | d;
      A_CLR:  mOut[sh +: 32] = mOut[sh +: 32] & ~d;
      A_RISE: mRise[sh +: 32] = d;
      A_FALL: mFall[sh +: 32] = d;
      A_MASK: mMask[sh +: 32] = d;
      A_TYPE: mType[sh +: 32] = d;
      A_POL:  mPol[sh +: 32] = d;
      A_STAT: mStat[sh +: 32] = mStat[sh +: 32] & ~d;
      default: ;
    endcase
    mStat = mStat | (mType & (mPad ^ mPol));
  endtask

  task automatic wrBoth(logic [11:0] base, logic [63:0] v);
    wrReg(base, 0, v[31:0]);
    wrReg(base, 1, v[63:32]);
  endtask

  task automatic applyPad(logic [63:0] nv);
    logic [63:0] pv;
    pv = mPad;
    @(negedge clk);
    padIn = nv;
    repeat (8) @(negedge clk);
    mStat = mStat | (~mType & ((nv & ~pv & mRise) | (~nv & pv & mFall)));
    mStat = mStat | (mType & (nv ^ mPol));
    mPad = nv;
  endtask

  task automatic checkStatus(string req);
    logic [63:0] s;
    rd64(A_STAT, s);
    check(req, s, mStat);
    check({req, " irq"}, {63'd0, irqOut}, {63'd0, |(mStat & mMask)});
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish();
    end
  end

  initial begin
    logic [31:0] w;
    logic [63:0] v, e;
    void'($urandom(32'd1234));
    #1 rstN = 1'b0;
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1 reset outputs", {padOut[62:0], irqOut}, 64'd0);
    check("R1 reset oe", padOe, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    rd64(A_RISE, v); check("R1 rise enables zero", v, 64'd0);
    rd64(A_FALL, v); check("R1 fall enables zero", v, 64'd0);
    rd64(A_DIR, v);  check("R1 direction zero", v, 64'd0);
    rd64(A_STAT, v); check("R1 status zero", v, 64'd0);

    // R5: live level through synchronizer
    for (int i = 0; i < 4; i++) begin
      applyPad({$urandom, $urandom});
      rd64(A_LEVEL, v);
      check("R5 level readback", v, mPad);
    end

    // R3 R4 R2: random direction and set/clear traffic on both banks
    for (int i = 0; i < 24; i++) begin
      int bank, op;
      bank = int'($urandom % 2);
      op = int'($urandom % 3);
      w = $urandom;
      if (op == 0) wrReg(A_DIR, bank, w);
      else if (op == 1) wrReg(A_SET, bank, w);
      else wrReg(A_CLR, bank, w);
      check("R4 R2 padOut latch", padOut, mOut);
      check("R3 R2 padOe", padOe, mDir);
    end
    rd64(A_DIR, v); check("R3 direction readback", v, mDir);
    rd(A_SET, w); check("R4 set reads zero", {32'd0, w}, 64'd0);
    rd(A_CLR + 12'd4, w); check("R4 clear reads zero", {32'd0, w}, 64'd0);
    wrReg(A_SET, 1, 32'd0);
    check("R4 zero set no effect", padOut, mOut);

    // R6 R11 R9: random edge configurations
    wrBoth(A_BYP, {$urandom, $urandom});
    wrBoth(A_RISE, {$urandom, $urandom});
    wrBoth(A_FALL, {$urandom, $urandom});
    wrBoth(A_MASK, {$urandom, $urandom});
    for (int i = 0; i < 20; i++) begin
      applyPad(mPad ^ ({$urandom, $urandom} & {$urandom, $urandom}));
      checkStatus("R6 edge status");
      check("R11 no enable no status", mStat & ~(mRise | mFall), 64'd0);
      if (i % 5 == 4) begin
        e = {$urandom, $urandom};
        wrBoth(A_STAT, e); // R8
        checkStatus("R8 partial w1c");
      end
    end

    // R9: mask gating
    wrBoth(A_MASK, 64'd0);
    check("R9 masked irq low", {63'd0, irqOut}, 64'd0);
    wrBoth(A_STAT, '1);
    wrBoth(A_RISE, 64'd0);
    wrBoth(A_FALL, 64'd0);
    wrBoth(A_BYP, 64'd0);
    applyPad(64'd0);
    checkStatus("R8 full clear");

    // R7: level mode active high on pin 3
    wrReg(A_MASK, 0, 32'h8);
    wrReg(A_POL, 0, 32'h0);
    wrReg(A_TYPE, 0, 32'h8);
    applyPad(64'h8);
    checkStatus("R7 level high sets");
    check("R7 level irq", {63'd0, irqOut}, 64'd1);
    wrReg(A_STAT, 0, 32'h8);
    checkStatus("R7 clear while active");
    applyPad(64'h0);
    checkStatus("R7 latched after release");
    wrReg(A_STAT, 0, 32'h8);
    checkStatus("R8 clear after release");
    check("R9 irq drops", {63'd0, irqOut}, 64'd0);

    // R7 R2: active-low on pin 40 (bank 1 bit 8), polarity before type
    applyPad(64'd1 << 40);
    wrReg(A_POL, 1, 32'h100);
    wrReg(A_TYPE, 1, 32'h100);
    rd(A_STAT + 12'd4, w);
    check("R7 R2 no spurious level", {32'd0, w}, 64'd0);
    applyPad(64'd0);
    rd(A_STAT + 12'd4, w);
    check("R7 R2 active low sets", {32'd0, w}, 64'h100);
    wrReg(A_TYPE, 1, 32'h0);
    wrReg(A_STAT, 1, 32'h100);
    wrReg(A_TYPE, 0, 32'h0);
    wrReg(A_STAT, 0, 32'h8);

    // R10: glitch filter on pin 5
    wrReg(A_RISE, 0, 32'h20);
    @(negedge clk); padIn[5] = 1'b1;
    @(negedge clk); padIn[5] = 1'b0;
    repeat (8) @(negedge clk);
    rd(A_STAT, w);
    check("R10 one-cycle pulse filtered", {32'd0, w}, 64'd0);
    @(negedge clk); padIn[5] = 1'b1;
    repeat (2) @(negedge clk); padIn[5] = 1'b0;
    repeat (8) @(negedge clk);
    rd(A_STAT, w);
    check("R10 two-cycle pulse passes", {32'd0, w}, 64'h20);
    wrReg(A_STAT, 0, 32'h20);
    wrReg(A_BYP, 0, 32'h20);
    @(negedge clk); padIn[5] = 1'b1;
    @(negedge clk); padIn[5] = 1'b0;
    repeat (8) @(negedge clk);
    rd(A_STAT, w);
    check("R10 bypass sees pulse", {32'd0, w}, 64'h20);

    done = 1'b1;
    finish();
  end
endmodule